// File: doc/BRIEF.md
# Receiver Event Interrupt Controller

This block collects seven status events from a cable receiver datapath and presents them to a host as one interrupt line and a 7-bit status word. The events come from several kinds of signal:
- the two edges of a frame-lock level;
- two single-cycle strobes, one for an uncorrectable packet and one for a refreshed bit-error-rate measurement;
- two magnitude comparisons of measured values against host thresholds;
- a check that the 8-bit gain word has reached either end of its range.

Each source has its own select bit. A selected event sets its status bit, and the bit stays set until the host reads the status word. The read clears the whole word.

The host sets the global enable to use the pin as an interrupt. With the enable low, the same pin becomes a general-purpose control output, and its level is taken from the top select bit. Level conditions (the two comparisons and the gain limit) are turned into events on their rising edge, so a condition that persists raises one interrupt and not a stream of them. The generators of the events are outside this block.

Top module: `rx_irq_ctrl`

## Requirements
- R1: While reset is high, and in the first cycle after it, the status word is 0.
- R2: Bit 0 sets when the lock flag goes from 0 to 1. A flag that is already 1 when reset is released gives no event.
- R3: Bit 1 sets when the lock flag goes from 1 to 0.
- R4: Bit 2 sets one cycle after a cycle with the uncorrectable-packet strobe high.
- R5: Bit 3 sets one cycle after a cycle with the error-rate refresh strobe high.
- R6: Bit 4 sets when the high-side measurement becomes strictly greater than its threshold. Equality does not set it.
- R7: Bit 5 sets when the low-side measurement becomes strictly less than its threshold. Equality does not set it.
- R8: Bit 6 sets when the gain word becomes 0 or 255.
- R9: An event whose select bit is 0 leaves its status bit at 0.
- R10: A status bit stays set until a cycle with the read strobe high. After that cycle, the whole status word is 0.
- R11: An event in the same cycle as a read is kept in the status word after the clear.
- R12: With the enable at 1, the pin is high exactly when any status bit is 1.
- R13: With the enable at 0, the pin equals select bit 6, whatever the status.
- R14: A level condition that stays true across a read does not set its bit again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| sync_lock | input | 1 | Frame-lock level |
| pkt_uncorr | input | 1 | Uncorrectable-packet strobe |
| ber_refresh | input | 1 | Error-rate refresh strobe |
| meas_hi | input | 8 | Measurement compared for "above" |
| thr_hi | input | 8 | Threshold for meas_hi |
| meas_lo | input | 8 | Measurement compared for "below" |
| thr_lo | input | 8 | Threshold for meas_lo |
| gain | input | 8 | Gain control word |
| src_sel | input | 7 | Per-source select; bit 6 also drives the pin when disabled |
| irq_en | input | 1 | 1: pin is interrupt; 0: pin is control output |
| stat_rd | input | 1 | Status read strobe (clears after this cycle) |
| irq_o | output | 1 | Interrupt / control pin, active high |
| stat_o | output | 7 | Status word, bit i matches select bit i |

## Verification
An input change in cycle N shows in the status word after the clock edge that ends cycle N, one register later. The two edge sources and the three level sources compare the inputs with their values from the previous cycle. The pin follows the status word with no further delay in interrupt mode, and follows the enable and select bit with no delay in control mode. The driver applies each cycle's inputs on the falling edge and queues the expected status and pin for the next rising edge. The monitor compares them one nanosecond after that edge.

// File: rtl/rx_irq_pkg.sv
package rx_irq_pkg;

    localparam int NUM_SRC = 7;
    localparam int DATA_W  = 8;
    localparam int NUM_LVL = 5;

    typedef enum int {
        SRC_LOCK_UP = 0,
        SRC_LOCK_DN = 1,
        SRC_UNCORR  = 2,
        SRC_BER     = 3,
        SRC_ABOVE   = 4,
        SRC_BELOW   = 5,
        SRC_GAIN    = 6
    } src_idx_e;

    typedef enum int {
        LVL_LOCK    = 0,
        LVL_UNLOCK  = 1,
        LVL_ABOVE   = 2,
        LVL_BELOW   = 3,
        LVL_GAIN    = 4
    } lvl_idx_e;

    typedef logic [NUM_SRC-1:0] src_vec_t;

    typedef struct packed {
        logic above;
        logic below;
        logic at_lim;
    } cond_t;

    function automatic src_vec_t next_status(input src_vec_t cur, input src_vec_t evt,
                                             input src_vec_t sel, input logic rd);
        src_vec_t kept;
        kept = rd ? '0 : cur;
        return kept | (evt & sel);
    endfunction

endpackage

// File: rtl/rx_irq_cond.sv
module rx_irq_cond
    import rx_irq_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic [W-1:0] meas_hi,
    input  logic [W-1:0] thr_hi,
    input  logic [W-1:0] meas_lo,
    input  logic [W-1:0] thr_lo,
    input  logic [W-1:0] gain,
    output cond_t        cond
);
    localparam logic [W-1:0] GAIN_MIN = '0;
    localparam logic [W-1:0] GAIN_MAX = '1;

    always_comb begin
        cond.above  = meas_hi > thr_hi;
        cond.below  = meas_lo < thr_lo;
        cond.at_lim = (gain == GAIN_MIN) || (gain == GAIN_MAX);
    end
endmodule

// File: rtl/rx_irq_edge.sv
module rx_irq_edge #(
    parameter int N = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] lvl_q;
    logic         armed_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            lvl_q   <= '0;
            armed_q <= 1'b0;
        end else begin
            lvl_q   <= lvl;
            armed_q <= 1'b1;
        end
    end

    // Edges count only once a true previous value has been captured.
    for (genvar i = 0; i < N; i++) begin : g_edge
        assign rise[i] = armed_q & lvl[i] & ~lvl_q[i];
    end
endmodule

// File: rtl/rx_irq_status.sv
module rx_irq_status
    import rx_irq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t evt,
    input  src_vec_t sel,
    input  logic     rd,
    output src_vec_t stat
);
    src_vec_t stat_q;

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= next_status(stat_q, evt, sel, rd);
    end

    assign stat = stat_q;
endmodule

// File: rtl/rx_irq_pin.sv
module rx_irq_pin
    import rx_irq_pkg::*;
(
    input  logic     en,
    input  src_vec_t sel,
    input  src_vec_t stat,
    output logic     pin
);
    always_comb begin
        if (en) pin = |stat;
        else    pin = sel[NUM_SRC-1];
    end
endmodule

// File: rtl/rx_irq_ctrl.sv
module rx_irq_ctrl
    import rx_irq_pkg::*;
#(
    parameter int W = DATA_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               sync_lock,
    input  logic               pkt_uncorr,
    input  logic               ber_refresh,
    input  logic [W-1:0]       meas_hi,
    input  logic [W-1:0]       thr_hi,
    input  logic [W-1:0]       meas_lo,
    input  logic [W-1:0]       thr_lo,
    input  logic [W-1:0]       gain,
    input  logic [NUM_SRC-1:0] src_sel,
    input  logic               irq_en,
    input  logic               stat_rd,
    output logic               irq_o,
    output logic [NUM_SRC-1:0] stat_o
);
    cond_t              cond;
    logic [NUM_LVL-1:0] lvl;
    logic [NUM_LVL-1:0] lvl_rise;
    src_vec_t           evt;
    src_vec_t           stat;

    rx_irq_cond #(.W(W)) u_cond (
        .meas_hi (meas_hi),
        .thr_hi  (thr_hi),
        .meas_lo (meas_lo),
        .thr_lo  (thr_lo),
        .gain    (gain),
        .cond    (cond)
    );

    always_comb begin
        lvl              = '0;
        lvl[LVL_LOCK]    = sync_lock;
        lvl[LVL_UNLOCK]  = ~sync_lock;
        lvl[LVL_ABOVE]   = cond.above;
        lvl[LVL_BELOW]   = cond.below;
        lvl[LVL_GAIN]    = cond.at_lim;
    end

    rx_irq_edge #(.N(NUM_LVL)) u_edge (
        .clk  (clk),
        .rst  (rst),
        .lvl  (lvl),
        .rise (lvl_rise)
    );

    always_comb begin
        evt              = '0;
        evt[SRC_LOCK_UP] = lvl_rise[LVL_LOCK];
        evt[SRC_LOCK_DN] = lvl_rise[LVL_UNLOCK];
        evt[SRC_UNCORR]  = pkt_uncorr;
        evt[SRC_BER]     = ber_refresh;
        evt[SRC_ABOVE]   = lvl_rise[LVL_ABOVE];
        evt[SRC_BELOW]   = lvl_rise[LVL_BELOW];
        evt[SRC_GAIN]    = lvl_rise[LVL_GAIN];
    end

    rx_irq_status u_status (
        .clk  (clk),
        .rst  (rst),
        .evt  (evt),
        .sel  (src_sel),
        .rd   (stat_rd),
        .stat (stat)
    );

    rx_irq_pin u_pin (
        .en   (irq_en),
        .sel  (src_sel),
        .stat (stat),
        .pin  (irq_o)
    );

    assign stat_o = stat;
endmodule

// File: rtl/rx_irq_ctrl_chk.sv
module rx_irq_ctrl_chk
    import rx_irq_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               pkt_uncorr,
    input logic               ber_refresh,
    input logic [NUM_SRC-1:0] src_sel,
    input logic               irq_en,
    input logic               stat_rd,
    input logic               irq_o,
    input logic [NUM_SRC-1:0] stat_o
);
    a_r1_reset_clear: assert property (@(posedge clk) rst |=> stat_o == '0);

    a_r4_uncorr_sets: assert property (@(posedge clk) disable iff (rst)
        (pkt_uncorr && src_sel[SRC_UNCORR]) |=> stat_o[SRC_UNCORR]);

    a_r5_ber_sets: assert property (@(posedge clk) disable iff (rst)
        (ber_refresh && src_sel[SRC_BER]) |=> stat_o[SRC_BER]);

    a_r9_masked_stays_low: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> ((stat_o & ~$past(stat_o) & ~$past(src_sel)) == '0));

    a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
        !stat_rd |=> ((stat_o & $past(stat_o)) == $past(stat_o)));

    a_r12_pin_or: assert property (@(posedge clk) disable iff (rst)
        irq_en |-> (irq_o == (stat_o != '0)));

    a_r13_ctrl_out: assert property (@(posedge clk) disable iff (rst)
        !irq_en |-> (irq_o == src_sel[NUM_SRC-1]));
endmodule

bind rx_irq_ctrl rx_irq_ctrl_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .pkt_uncorr  (pkt_uncorr),
    .ber_refresh (ber_refresh),
    .src_sel     (src_sel),
    .irq_en      (irq_en),
    .stat_rd     (stat_rd),
    .irq_o       (irq_o),
    .stat_o      (stat_o)
);

// File: tb/rx_irq_ctrl_tb.sv
module rx_irq_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       sync_lock = 1'b1;
    logic       pkt_uncorr = 1'b0;
    logic       ber_refresh = 1'b0;
    logic [7:0] meas_hi = 8'd10, thr_hi = 8'd50;
    logic [7:0] meas_lo = 8'd100, thr_lo = 8'd50;
    logic [7:0] gain = 8'd100;
    logic [6:0] src_sel = 7'h7F;
    logic       irq_en = 1'b1;
    logic       stat_rd = 1'b0;
    logic       irq_o;
    logic [6:0] stat_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        logic [6:0] stat;
        logic       irq;
        string      req;
    } exp_t;
    exp_t q[$];

    // reference state
    logic [6:0] m_stat = '0;
    logic       m_lock = 1'b0, m_above = 1'b0, m_below = 1'b0, m_lim = 1'b0;
    logic       m_armed = 1'b0;

    always #2.5 clk = ~clk;

    rx_irq_ctrl u_dut (
        .clk(clk), .rst(rst), .sync_lock(sync_lock), .pkt_uncorr(pkt_uncorr),
        .ber_refresh(ber_refresh), .meas_hi(meas_hi), .thr_hi(thr_hi),
        .meas_lo(meas_lo), .thr_lo(thr_lo), .gain(gain), .src_sel(src_sel),
        .irq_en(irq_en), .stat_rd(stat_rd), .irq_o(irq_o), .stat_o(stat_o)
    );

    task automatic check(input string req, input logic [6:0] a_st, input logic [6:0] e_st,
                         input logic a_irq, input logic e_irq);
        checks++;
        if (a_st !== e_st || a_irq !== e_irq) begin
            errors++;
            $display("FAIL %s: stat=%h irq=%b expected stat=%h irq=%b",
                     req, a_st, a_irq, e_st, e_irq);
        end
    endtask

    // driver: inputs already set for this cycle; predict next edge, then move to next falling edge
    task automatic step(input string req);
        logic [6:0] ev;
        logic ab, bl, lm;
        exp_t e;
        ab = meas_hi > thr_hi;
        bl = meas_lo < thr_lo;
        lm = (gain == 8'd0) || (gain == 8'd255);
        ev = '0;
        ev[0] = m_armed &  sync_lock & ~m_lock;
        ev[1] = m_armed & ~sync_lock &  m_lock;
        ev[2] = pkt_uncorr;
        ev[3] = ber_refresh;
        ev[4] = m_armed & ab & ~m_above;
        ev[5] = m_armed & bl & ~m_below;
        ev[6] = m_armed & lm & ~m_lim;
        m_stat = (stat_rd ? 7'h00 : m_stat) | (ev & src_sel);
        m_lock = sync_lock; m_above = ab; m_below = bl; m_lim = lm; m_armed = 1'b1;
        e.stat = m_stat;
        e.irq  = irq_en ? (m_stat != 7'h00) : src_sel[6];
        e.req  = req;
        q.push_back(e);
        @(negedge clk);
    endtask

    // monitor
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                check(e.req, stat_o, e.stat, irq_o, e.irq);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", stat_o, 7'h00, irq_o, 1'b0);
        rst = 1'b0;
        // lock already high at reset release: no R2 event
        step("R1"); step("R2");
        // R3 lock loss
        sync_lock = 1'b0; step("R3");
        step("R10");                       // sticky
        stat_rd = 1'b1; step("R10");
        stat_rd = 1'b0; step("R10");
        // R2 lock gain
        sync_lock = 1'b1; step("R2");
        stat_rd = 1'b1; step("R10");
        stat_rd = 1'b0;
        // R4 / R5 strobes
        pkt_uncorr = 1'b1; step("R4");
        pkt_uncorr = 1'b0; ber_refresh = 1'b1; step("R5");
        ber_refresh = 1'b0; step("R12");
        stat_rd = 1'b1; step("R10");
        stat_rd = 1'b0;
        // R6 above: equal first, then greater
        meas_hi = 8'd50; step("R6");
        meas_hi = 8'd51; step("R6");
        stat_rd = 1'b1; step("R10");
        stat_rd = 1'b0; step("R14");
        step("R14");
        meas_hi = 8'd10; step("R14");
        // R7 below
        meas_lo = 8'd50; step("R7");
        meas_lo = 8'd49; step("R7");
        stat_rd = 1'b1; meas_lo = 8'd100; step("R10");
        stat_rd = 1'b0;
        // R8 gain limits
        gain = 8'd0; step("R8");
        stat_rd = 1'b1; gain = 8'd100; step("R8");
        stat_rd = 1'b0; gain = 8'd255; step("R8");
        stat_rd = 1'b1; step("R14");
        stat_rd = 1'b0; gain = 8'd254; step("R8");
        // R9 masking
        src_sel = 7'h00; pkt_uncorr = 1'b1; ber_refresh = 1'b1; step("R9");
        pkt_uncorr = 1'b0; ber_refresh = 1'b0; sync_lock = 1'b0; step("R9");
        src_sel = 7'h7F; step("R9");
        // R11 event with read
        stat_rd = 1'b1; pkt_uncorr = 1'b1; step("R11");
        stat_rd = 1'b0; pkt_uncorr = 1'b0; step("R11");
        // R13 control mode
        irq_en = 1'b0; src_sel = 7'h40; step("R13");
        src_sel = 7'h3F; step("R13");
        src_sel = 7'h00; step("R13");
        irq_en = 1'b1; src_sel = 7'h7F; step("R12");
        stat_rd = 1'b1; step("R12");
        stat_rd = 1'b0; step("R12");
        repeat (3) @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #20000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule